// File: doc/BRIEF.md
# Compare Timer with Prescaler

This block is a memory-mapped up-counter for use as a system tick or an event timer. Software programs it through a word-addressed register bus (write enable, address, write data, registered read data). The counter advances on one of two clock-enable tick inputs, a fast one and a slow one, after a programmable divider. Three compare registers raise sticky match flags. A rollover flag marks a wrap past all ones. Status flags are masked by an enable register to drive one level interrupt.

Two counting modes exist. In free-run mode the counter wraps at all ones. In restart mode it returns to zero after reaching compare 1, and any write to compare 1 resets it. A software reset clears the run-control bits and the timer state but keeps the mode and clock-select bits. An enable-mode bit chooses whether enabling the timer restarts the count or resumes it.

Word addresses: 0 control, 1 prescaler, 2 status, 3 interrupt enable, 4 to 6 compare 1 to 3, 7 and 8 capture (unused), 9 counter. Read data appears one cycle after the address. The interrupt output is registered and follows the status one cycle later.

Top module: `cmp_timer`

## Requirements
- R1: After reset, control, prescaler, status, interrupt enable and counter read 0, all three compare registers read all ones of the counter width, and the interrupt is low.
- R2: A control write stores the value with bits 2, 4 and 10 to 14 forced to 0. Bit 15 always reads back as 0.
- R3: Clock source is control bits 8:6. Codes 001 and 010 select the fast tick and 100 selects the slow tick. Every other code selects no tick, so the counter holds.
- R4: The prescaler register keeps bits 11:0 only. While enabled, the counter advances once per (prescaler+1) selected ticks.
- R5: In free-run mode (control bit 9 = 1) a step from all ones gives 0 and sets status bit 5 (rollover).
- R6: In restart mode (control bit 9 = 0) a step taken while the counter equals compare 1 gives 0. Any write to compare 1 in this mode zeroes the counter. In free-run mode a compare 1 write leaves the counter as it is.
- R7: A step that loads the counter with the value of compare n (n = 1, 2, 3) sets status bit n-1. This happens whether or not that flag's interrupt enable is set.
- R8: Writing 1 to a status bit clears it, and writing 0 leaves it. The interrupt enable register keeps bits 5:0 only, with the same bit layout as status.
- R9: The interrupt is high one cycle after (status AND interrupt enable) is nonzero while control bit 0 (enable) is set, and low otherwise.
- R10: A control write with bit 15 set clears control bits 5:0 and keeps the rest. It zeroes status, prescaler, interrupt enable and the counter, and sets all compare registers to all ones.
- R11: The counter holds while control bit 0 is clear. When bit 0 goes from 0 to 1 with control bit 1 set, the counter restarts from 0. With bit 1 clear, it resumes from the held value.
- R12: Capture addresses 7 and 8 read 0, and writes to the counter address have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered, valid one cycle after the address |
| tick_fast | input | 1 | Fast clock-enable tick |
| tick_slow | input | 1 | Slow clock-enable tick |
| irq | output | 1 | Level interrupt, registered |

## Verification
The assertions assume that the tick inputs are single-cycle-wide enables sampled at the clock, and that the bus does not write a register in the same cycle as a counter step it is meant to observe. The directed tasks keep these assumptions: ticks are pulsed only between bus accesses, and every register read happens while both ticks are low. This makes the counter value at each read exact. The bench uses an 8-bit counter so that wrap and compare-at-all-ones cases can be reached in a few hundred cycles.

// File: rtl/cmpt_pkg.sv
package cmpt_pkg;
  localparam int ADDR_W = 4;
  localparam int NCMP   = 3;
  localparam int ST_W   = 6;
  localparam int ST_ROLL = 5;

  localparam logic [ADDR_W-1:0] A_CTRL = 4'd0;
  localparam logic [ADDR_W-1:0] A_PRE  = 4'd1;
  localparam logic [ADDR_W-1:0] A_STAT = 4'd2;
  localparam logic [ADDR_W-1:0] A_IEN  = 4'd3;
  localparam logic [ADDR_W-1:0] A_CMP1 = 4'd4;
  localparam logic [ADDR_W-1:0] A_CAP1 = 4'd7;
  localparam logic [ADDR_W-1:0] A_CAP2 = 4'd8;
  localparam logic [ADDR_W-1:0] A_CNT  = 4'd9;

  localparam int B_EN    = 0;
  localparam int B_RSTMD = 1;
  localparam int B_SRC   = 6;
  localparam int B_FREE  = 9;
  localparam int B_SWR   = 15;

  localparam logic [31:0] CTRL_FORCE0 = 32'h0000_7C14;
  localparam logic [31:0] SWR_CLEAR   = 32'h0000_803F;

  typedef enum logic [1:0] {SRC_NONE, SRC_FAST, SRC_SLOW} src_e;

  function automatic src_e src_decode(input logic [2:0] code);
    case (code)
      3'b001, 3'b010: src_decode = SRC_FAST;
      3'b100:         src_decode = SRC_SLOW;
      default:        src_decode = SRC_NONE;
    endcase
  endfunction
endpackage

// File: rtl/cmpt_tick_gen.sv
module cmpt_tick_gen #(
  parameter int PRE_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             run,
  input  logic [2:0]       src_code,
  input  logic [PRE_W-1:0] pre,
  input  logic             tick_fast,
  input  logic             tick_slow,
  output logic             step
);
  import cmpt_pkg::*;

  logic             tick_sel;
  logic [PRE_W-1:0] div_q;
  logic             div_end;

  always_comb begin
    case (src_decode(src_code))
      SRC_FAST: tick_sel = tick_fast;
      SRC_SLOW: tick_sel = tick_slow;
      default:  tick_sel = 1'b0;
    endcase
  end

  assign div_end = (div_q >= pre);
  assign step    = run && tick_sel && div_end;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      div_q <= '0;
    end else if (run && tick_sel) begin
      if (div_end) div_q <= '0;
      else         div_q <= div_q + 1'b1;
    end
  end

  assert_step_has_tick_R3: assert property (@(posedge clk) disable iff (rst)
    step |-> (tick_fast || tick_slow));
  assert_step_needs_run_R11: assert property (@(posedge clk) disable iff (rst)
    step |-> run);
endmodule

// File: rtl/cmpt_counter.sv
module cmpt_counter #(
  parameter int CNT_W = 32,
  parameter int NCH   = 3
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      clr,
  input  logic                      step,
  input  logic                      freerun,
  input  logic [NCH-1:0][CNT_W-1:0] cmp,
  output logic [CNT_W-1:0]          count,
  output logic [NCH-1:0]            hit,
  output logic                      roll
);
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] nxt;
  logic             at_max;
  logic             at_top;

  assign at_max = (count == CMAX);
  assign at_top = !freerun && (count == cmp[0]);
  assign nxt    = (at_max || at_top) ? '0 : count + 1'b1;
  assign roll   = step && at_max;

  for (genvar i = 0; i < NCH; i++) begin : g_match
    assign hit[i] = step && (nxt == cmp[i]);
  end

  always_ff @(posedge clk) begin
    if (rst || clr)  count <= '0;
    else if (step)   count <= nxt;
  end

  assert_wrap_to_zero_R5: assert property (@(posedge clk) disable iff (rst)
    (step && count == CMAX) |=> (count == '0));
  assert_restart_at_cmp1_R6: assert property (@(posedge clk) disable iff (rst)
    (step && !freerun && count == cmp[0]) |=> (count == '0));
  assert_hold_without_step_R11: assert property (@(posedge clk) disable iff (rst)
    (!step && !clr) |=> $stable(count));
endmodule

// File: rtl/cmp_timer.sv
module cmp_timer #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32,
  parameter int PRE_W  = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic [3:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              tick_fast,
  input  logic              tick_slow,
  output logic              irq
);
  import cmpt_pkg::*;

  logic [DATA_W-1:0]          ctrl_q;
  logic [PRE_W-1:0]           pre_q;
  logic [ST_W-1:0]            stat_q;
  logic [ST_W-1:0]            ien_q;
  logic [NCMP-1:0][CNT_W-1:0] cmp_q;
  logic [CNT_W-1:0]           count;
  logic [NCMP-1:0]            hit;
  logic                       roll;
  logic                       step;

  logic              wr_ctrl, swr, en_rise, cnt_clr;
  logic [DATA_W-1:0] ctrl_in;
  logic [ST_W-1:0]   st_clr, st_set;

  assign wr_ctrl = bus_we && (bus_addr == A_CTRL);
  assign ctrl_in = bus_wdata & ~CTRL_FORCE0;
  assign swr     = wr_ctrl && bus_wdata[B_SWR];
  assign en_rise = wr_ctrl && !swr && !ctrl_q[B_EN] && bus_wdata[B_EN];
  assign cnt_clr = swr
                || (en_rise && bus_wdata[B_RSTMD])
                || (bus_we && bus_addr == A_CMP1 && !ctrl_q[B_FREE]);

  assign st_clr = (bus_we && bus_addr == A_STAT) ? bus_wdata[ST_W-1:0] : '0;

  always_comb begin
    st_set          = '0;
    st_set[NCMP-1:0] = hit;
    st_set[ST_ROLL] = roll;
  end

  cmpt_tick_gen #(.PRE_W(PRE_W)) u_tick (
    .clk       (clk),
    .rst       (rst),
    .clr       (cnt_clr),
    .run       (ctrl_q[B_EN]),
    .src_code  (ctrl_q[B_SRC+2:B_SRC]),
    .pre       (pre_q),
    .tick_fast (tick_fast),
    .tick_slow (tick_slow),
    .step      (step)
  );

  cmpt_counter #(.CNT_W(CNT_W), .NCH(NCMP)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .clr     (cnt_clr),
    .step    (step),
    .freerun (ctrl_q[B_FREE]),
    .cmp     (cmp_q),
    .count   (count),
    .hit     (hit),
    .roll    (roll)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      pre_q  <= '0;
      stat_q <= '0;
      ien_q  <= '0;
    end else if (swr) begin
      ctrl_q <= ctrl_in & ~SWR_CLEAR;
      pre_q  <= '0;
      stat_q <= '0;
      ien_q  <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= ctrl_in;
      if (bus_we && bus_addr == A_PRE) pre_q <= bus_wdata[PRE_W-1:0];
      if (bus_we && bus_addr == A_IEN) ien_q <= bus_wdata[ST_W-1:0];
      stat_q <= (stat_q & ~st_clr) | st_set;
    end
  end

  for (genvar i = 0; i < NCMP; i++) begin : g_cmp
    always_ff @(posedge clk) begin
      if (rst || swr)
        cmp_q[i] <= {CNT_W{1'b1}};
      else if (bus_we && bus_addr == A_CMP1 + 4'(i))
        cmp_q[i] <= bus_wdata[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      irq <= ctrl_q[B_EN] && |(stat_q & ien_q);
      case (bus_addr)
        A_CTRL:          bus_rdata <= ctrl_q;
        A_PRE:           bus_rdata <= DATA_W'(pre_q);
        A_STAT:          bus_rdata <= DATA_W'(stat_q);
        A_IEN:           bus_rdata <= DATA_W'(ien_q);
        4'd4:            bus_rdata <= DATA_W'(cmp_q[0]);
        4'd5:            bus_rdata <= DATA_W'(cmp_q[1]);
        4'd6:            bus_rdata <= DATA_W'(cmp_q[2]);
        A_CAP1, A_CAP2:  bus_rdata <= '0;
        A_CNT:           bus_rdata <= DATA_W'(count);
        default:         bus_rdata <= '0;
      endcase
    end
  end

  assert_irq_gated_by_enable_R9: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(ctrl_q[B_EN]));
  assert_swr_clears_state_R10: assert property (@(posedge clk) disable iff (rst)
    swr |=> (stat_q == '0 && ien_q == '0 && pre_q == '0 && count == '0 && !ctrl_q[B_EN]));
  assert_flags_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    (!swr && !(bus_we && bus_addr == A_STAT)) |=> ((stat_q & $past(stat_q)) == $past(stat_q)));
endmodule

// File: tb/cmp_timer_test.sv
module cmp_timer_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        we = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        tf = 1'b0;
  logic        ts = 1'b0;
  logic [31:0] rdata;
  logic        irq;
  int          vectors = 0;
  int          errs = 0;
  logic [31:0] v;

  always #2 clk = ~clk;

  cmp_timer #(.DATA_W(32), .CNT_W(8), .PRE_W(12)) uut (
    .clk(clk), .rst(rst), .bus_we(we), .bus_addr(addr), .bus_wdata(wdata),
    .bus_rdata(rdata), .tick_fast(tf), .tick_slow(ts), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk); addr = a;
    @(negedge clk); d = rdata;
  endtask

  task automatic rchk(input string req, input logic [3:0] a, input logic [31:0] exp);
    logic [31:0] t;
    rd(a, t);
    check(req, t, exp);
  endtask

  task automatic pulse(input bit fast, input int n);
    @(negedge clk);
    if (fast) tf = 1'b1; else ts = 1'b1;
    for (int i = 1; i < n; i++) @(negedge clk);
    @(negedge clk); tf = 1'b0; ts = 1'b0;
  endtask

  task automatic irq_chk(input string req, input logic exp);
    @(negedge clk); @(negedge clk);
    check(req, {31'b0, irq}, {31'b0, exp});
  endtask

  task automatic t_reset;
    rchk("R1 ctrl", 4'd0, 32'h0);
    rchk("R1 pre", 4'd1, 32'h0);
    rchk("R1 stat", 4'd2, 32'h0);
    rchk("R1 ien", 4'd3, 32'h0);
    rchk("R1 cmp1", 4'd4, 32'hFF);
    rchk("R1 cmp3", 4'd6, 32'hFF);
    rchk("R1 count", 4'd9, 32'h0);
    irq_chk("R1 irq", 1'b0);
  endtask

  task automatic t_ctrl_mask;
    wr(4'd0, 32'hFFFF_7FFF);
    rchk("R2 masked ctrl", 4'd0, 32'hFFFF_03EB);
    pulse(1, 3);
    rchk("R3 source 111 holds", 4'd9, 32'h0);
    wr(4'd0, 32'h0);
  endtask

  task automatic t_clksrc;
    wr(4'd0, 32'h241);
    pulse(1, 5);  rchk("R3 code 001 fast", 4'd9, 32'd5);
    pulse(0, 3);  rchk("R3 code 001 ignores slow", 4'd9, 32'd5);
    wr(4'd0, 32'h301);
    pulse(0, 3);  rchk("R3 code 100 slow", 4'd9, 32'd8);
    pulse(1, 2);  rchk("R3 code 100 ignores fast", 4'd9, 32'd8);
    wr(4'd0, 32'h281);
    pulse(1, 2);  rchk("R3 code 010 fast", 4'd9, 32'd10);
    wr(4'd0, 32'h2C1);
    pulse(1, 3);  rchk("R3 code 011 none", 4'd9, 32'd10);
  endtask

  task automatic t_prescale;
    wr(4'd0, 32'h241);
    wr(4'd1, 32'h0000_1002);
    rchk("R4 prescaler 12 bits", 4'd1, 32'd2);
    pulse(1, 2);  rchk("R4 two ticks no step", 4'd9, 32'd10);
    pulse(1, 1);  rchk("R4 third tick steps", 4'd9, 32'd11);
    pulse(1, 6);  rchk("R4 six ticks two steps", 4'd9, 32'd13);
    wr(4'd1, 32'd0);
  endtask

  task automatic t_enmode;
    wr(4'd0, 32'h240);
    pulse(1, 4);  rchk("R11 disabled holds", 4'd9, 32'd13);
    wr(4'd0, 32'h241);
    rchk("R11 resume keeps value", 4'd9, 32'd13);
    pulse(1, 1);  rchk("R11 resume counts", 4'd9, 32'd14);
    wr(4'd0, 32'h240);
    wr(4'd0, 32'h243);
    rchk("R11 restart from zero", 4'd9, 32'd0);
    pulse(1, 2);
    wr(4'd9, 32'h55);
    rchk("R12 counter read-only", 4'd9, 32'd2);
  endtask

  task automatic t_flags;
    wr(4'd5, 32'd10);
    wr(4'd6, 32'd6);
    wr(4'd3, 32'hFFFF_FF02);
    rchk("R8 ien 6 bits", 4'd3, 32'h02);
    pulse(1, 3);  rchk("R7 no match yet", 4'd2, 32'h0);
    pulse(1, 1);  rchk("R7 cmp3 flag without enable", 4'd2, 32'h04);
    irq_chk("R9 masked flag no irq", 1'b0);
    pulse(1, 4);  rchk("R7 cmp2 flag", 4'd2, 32'h06);
    irq_chk("R9 enabled flag irq", 1'b1);
    wr(4'd2, 32'h02);
    rchk("R8 write one clears", 4'd2, 32'h04);
    irq_chk("R9 irq drops", 1'b0);
    wr(4'd0, 32'h242);
    wr(4'd3, 32'h04);
    irq_chk("R9 disabled no irq", 1'b0);
    wr(4'd0, 32'h243);
    irq_chk("R9 enabled irq", 1'b1);
    wr(4'd2, 32'h3F);
    rchk("R8 clear all", 4'd2, 32'h0);
  endtask

  task automatic t_rollover;
    wr(4'd3, 32'h20);
    pulse(1, 255);
    rchk("R5 count at max", 4'd9, 32'hFF);
    rd(4'd2, v);  check("R5 no rollover yet", {31'b0, v[5]}, 32'd0);
    pulse(1, 1);
    rchk("R5 wrapped", 4'd9, 32'd0);
    rd(4'd2, v);  check("R5 rollover flag", {31'b0, v[5]}, 32'd1);
    irq_chk("R9 rollover irq", 1'b1);
    wr(4'd2, 32'h3F);
  endtask

  task automatic t_restart;
    pulse(1, 3);
    wr(4'd4, 32'h40);
    rchk("R6 freerun cmp1 write keeps count", 4'd9, 32'd3);
    wr(4'd0, 32'h041);
    wr(4'd4, 32'd5);
    rchk("R6 cmp1 write zeroes", 4'd9, 32'd0);
    pulse(1, 5);  rchk("R6 reaches cmp1", 4'd9, 32'd5);
    rd(4'd2, v);  check("R7 cmp1 flag", {31'b0, v[0]}, 32'd1);
    pulse(1, 1);  rchk("R6 returns to zero", 4'd9, 32'd0);
    pulse(1, 2);
    wr(4'd4, 32'd5);
    rchk("R6 second cmp1 write zeroes", 4'd9, 32'd0);
  endtask

  task automatic t_capture;
    rchk("R12 capture 1 zero", 4'd7, 32'h0);
    rchk("R12 capture 2 zero", 4'd8, 32'h0);
  endtask

  task automatic t_swr;
    wr(4'd1, 32'd3);
    wr(4'd3, 32'h21);
    wr(4'd5, 32'h33);
    pulse(1, 4);
    wr(4'd0, 32'hC000_8243);
    rchk("R10 ctrl kept bits", 4'd0, 32'hC000_0240);
    rchk("R10 stat", 4'd2, 32'h0);
    rchk("R10 pre", 4'd1, 32'h0);
    rchk("R10 ien", 4'd3, 32'h0);
    rchk("R10 count", 4'd9, 32'h0);
    rchk("R10 cmp1", 4'd4, 32'hFF);
    rchk("R10 cmp2", 4'd5, 32'hFF);
    irq_chk("R10 irq", 1'b0);
    pulse(1, 3);
    rchk("R10 disabled after reset", 4'd9, 32'h0);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_ctrl_mask();
    t_clksrc();
    t_prescale();
    t_enmode();
    t_flags();
    t_rollover();
    t_restart();
    t_capture();
    t_swr();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end

  initial begin
    #400000;
    errs++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end
endmodule